// File: doc/BRIEF.md
# Serial Management Bus Slave Frame Decoder

This block is the slave side of a two-wire serial management bus. It watches the management clock and the bidirectional data line, both asynchronous to the system clock. It walks through each management frame field by field and turns a completed frame into one access on a simple register-file request port. A frame addresses the local register file only when its device-address field equals the value on the `phy_sel` configuration input. Frames addressed to any other device are treated as addressed to an absent device.

For a read, the decoder asks the register file for the word at the end of the turnaround field. It then takes over the data line and shifts the word out, most significant bit first. For any other opcode it collects sixteen data bits and issues a single write once the last bit has arrived. The data line is driven through an output value and an output enable, which feed an external tri-state pad.

Top module: `mdio_slave_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mdio_oe`, `rf_wr_req`, `rf_rd_req` and `start_err` are all 0.
- R2: A frame begins only when the data line is sampled 0 on a rising management clock edge that follows at least 32 consecutive rising edges with the line sampled 1. A 0 seen after a shorter run of ones clears the run count, and the frame bits that follow cause no register access.
- R3: After the start marker, the fields are sampled on rising management clock edges, most significant bit first, in this order: opcode (2 bits), device address (5), register number (5), turnaround (2), data (16). Opcode 2'b10 is a read. At the second turnaround edge, `rf_rd_req` pulses for one cycle with `rf_addr` equal to the register number, and `rf_rdata` is taken in that same cycle.
- R4: Read data is placed on `mdio_out` after falling management clock edges, most significant bit first. It is therefore valid at each of the 16 following rising edges. `mdio_oe` is 1 from the end of turnaround until the 16th data rising edge, and is 0 at all other times.
- R5: Opcodes 2'b00, 2'b01 and 2'b11 are writes. After the 16th data bit, exactly one `rf_wr_req` pulse is issued, carrying the register number on `rf_addr` and the received word on `rf_wdata`. No write request occurs earlier in the frame.
- R6: When the device address differs from `phy_sel`, a read returns 16'hFFFF on the data line and raises no `rf_rd_req`. A write raises no `rf_wr_req`.
- R7: A start-marker bit (the bit after the initial 0) sampled as 0 raises `start_err` for exactly one cycle. The frame is still decoded and executed.
- R8: After the data field the decoder returns to waiting for a preamble. Frames sent back to back, each with its own 32-bit preamble, are each executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_in | input | 1 | Management clock from the bus master (asynchronous) |
| mdio_in | input | 1 | Data line as seen at the pad (asynchronous) |
| phy_sel | input | 5 | Device address this slave answers to |
| rf_rdata | input | 16 | Register file read data, valid in the `rf_rd_req` cycle |
| mdio_out | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | Output enable for the data line pad |
| start_err | output | 1 | One-cycle pulse on a bad start-marker bit |
| rf_rd_req | output | 1 | Register read request, one cycle |
| rf_wr_req | output | 1 | Register write request, one cycle |
| rf_addr | output | 5 | Register number of the current frame |
| rf_wdata | output | 16 | Write data, valid with `rf_wr_req` |

## Verification
The bench acts as the bus master. It writes through each of the three write opcodes, then reads the words back. A correct read-back shows both the bit order and the falling-edge launch timing, since a shift off by one edge corrupts every word. Reads of a register that was never written show that `rf_addr` selects the right entry. Frames aimed at a foreign device address, a frame behind a 20-bit preamble and a frame with a corrupted start marker separate the absent-device, preamble-gating and error-flag paths from normal decoding.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam int OP_W   = 2;
    localparam int ADDR_W = 5;
    localparam int TA_W   = 2;
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W);

    localparam logic [OP_W-1:0] OP_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } frame_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic dat;
    } mdio_samp_t;

    function automatic logic is_read(input logic [OP_W-1:0] op);
        return op == OP_READ;
    endfunction

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync
    import mdio_slv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mdc_in,
    input  logic       mdio_in,
    output mdio_samp_t smp
);

    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] dat_q;
    logic              mdc_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_q[0] <= 1'b0;
                    dat_q[0] <= 1'b1;
                end else begin
                    mdc_q[0] <= mdc_in;
                    dat_q[0] <= mdio_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_q[i] <= 1'b0;
                    dat_q[i] <= 1'b1;
                end else begin
                    mdc_q[i] <= mdc_q[i-1];
                    dat_q[i] <= dat_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mdc_d <= 1'b0;
        else     mdc_d <= mdc_q[STAGES-1];
    end

    assign smp.rise = mdc_q[STAGES-1] & ~mdc_d;
    assign smp.fall = ~mdc_q[STAGES-1] & mdc_d;
    assign smp.dat  = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slv_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  mdio_samp_t        smp,
    input  logic [ADDR_W-1:0] phy_sel,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_rd_req,
    output logic              rf_wr_req,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              start_err
);

    localparam int PW = $clog2(PRE_MIN + 1);

    frame_st_e         st;
    logic [PW-1:0]     pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [OP_W-1:0]   op_f;
    logic [ADDR_W-1:0] phy_f;
    logic [ADDR_W-1:0] reg_f;
    logic [DATA_W-1:0] sh;
    logic              rd_mode;
    logic              match;
    logic              last_ta;

    assign match     = (phy_f == phy_sel);
    assign last_ta   = smp.rise && (st == ST_TA) && (bit_cnt == CNT_W'(TA_W - 1));
    assign rf_rd_req = last_ta && is_read(op_f) && match;
    assign rf_addr   = reg_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PRE;
            pre_cnt   <= '0;
            bit_cnt   <= '0;
            op_f      <= '0;
            phy_f     <= '0;
            reg_f     <= '0;
            sh        <= '0;
            rd_mode   <= 1'b0;
            rf_wr_req <= 1'b0;
            rf_wdata  <= '0;
            mdio_out  <= 1'b0;
            mdio_oe   <= 1'b0;
            start_err <= 1'b0;
        end else begin
            rf_wr_req <= 1'b0;
            start_err <= 1'b0;
            if (smp.rise) begin
                case (st)
                    ST_PRE: begin
                        if (smp.dat) begin
                            if (pre_cnt != PW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PW'(PRE_MIN)) st <= ST_START;
                            pre_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (!smp.dat) start_err <= 1'b1;
                        st      <= ST_OP;
                        bit_cnt <= '0;
                    end
                    ST_OP: begin
                        op_f <= {op_f[OP_W-2:0], smp.dat};
                        if (bit_cnt == CNT_W'(OP_W - 1)) begin
                            st      <= ST_PHY;
                            bit_cnt <= '0;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_PHY: begin
                        phy_f <= {phy_f[ADDR_W-2:0], smp.dat};
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            st      <= ST_REG;
                            bit_cnt <= '0;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_REG: begin
                        reg_f <= {reg_f[ADDR_W-2:0], smp.dat};
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            st      <= ST_TA;
                            bit_cnt <= '0;
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_TA: begin
                        if (last_ta) begin
                            st      <= ST_DATA;
                            bit_cnt <= '0;
                            if (is_read(op_f)) begin
                                rd_mode  <= 1'b1;
                                mdio_oe  <= 1'b1;
                                mdio_out <= 1'b0;
                                sh       <= match ? rf_rdata : '1;
                            end else begin
                                rd_mode <= 1'b0;
                                sh      <= '0;
                            end
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_DATA: begin
                        if (!rd_mode) sh <= {sh[DATA_W-2:0], smp.dat};
                        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                            st      <= ST_PRE;
                            pre_cnt <= '0;
                            bit_cnt <= '0;
                            mdio_oe <= 1'b0;
                            rd_mode <= 1'b0;
                            if (!rd_mode && match) begin
                                rf_wr_req <= 1'b1;
                                rf_wdata  <= {sh[DATA_W-2:0], smp.dat};
                            end
                        end else bit_cnt <= bit_cnt + 1'b1;
                    end
                    default: st <= ST_PRE;
                endcase
            end else if (smp.fall && st == ST_DATA && rd_mode) begin
                mdio_out <= sh[DATA_W-1];
                sh       <= {sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!mdio_oe && !rf_wr_req && !start_err));

    // R5
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd_req && rf_wr_req));

    // R3
    rd_then_oe_chk: assert property (@(posedge clk) disable iff (rst)
        rf_rd_req |=> mdio_oe);

    // R4
    oe_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (st == ST_DATA && rd_mode));

    // R6
    wr_match_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_req |-> (phy_f == phy_sel));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_err |=> !start_err);

endmodule

// File: rtl/mdio_slave_decoder.sv
module mdio_slave_decoder
    import mdio_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_MIN     = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mdc_in,
    input  logic        mdio_in,
    input  logic [4:0]  phy_sel,
    input  logic [15:0] rf_rdata,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        start_err,
    output logic        rf_rd_req,
    output logic        rf_wr_req,
    output logic [4:0]  rf_addr,
    output logic [15:0] rf_wdata
);

    mdio_samp_t smp;

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .mdc_in  (mdc_in),
        .mdio_in (mdio_in),
        .smp     (smp)
    );

    mdio_frame_fsm #(.PRE_MIN(PRE_MIN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .phy_sel   (phy_sel),
        .rf_rdata  (rf_rdata),
        .rf_rd_req (rf_rd_req),
        .rf_wr_req (rf_wr_req),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .start_err (start_err)
    );

endmodule

// File: tb/sim_mdio_slave_decoder.sv
module sim_mdio_slave_decoder;

    localparam int HALF = 8;
    localparam logic [4:0] MY_PHY = 5'h11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc_in = 1'b0;
    logic        mdio_in = 1'b1;
    logic [4:0]  phy_sel = MY_PHY;
    logic [15:0] rf_rdata;
    logic        mdio_out, mdio_oe, start_err, rf_rd_req, rf_wr_req;
    logic [4:0]  rf_addr;
    logic [15:0] rf_wdata;

    int checks = 0;
    int fails  = 0;
    int err_cnt = 0;
    int rd_cnt = 0;
    bit done = 0;

    logic [15:0] mem [32];
    logic [20:0] exp_q [$];

    always #5 clk = ~clk;

    mdio_slave_decoder u0 (
        .clk(clk), .rst(rst), .mdc_in(mdc_in), .mdio_in(mdio_in),
        .phy_sel(phy_sel), .rf_rdata(rf_rdata), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .start_err(start_err), .rf_rd_req(rf_rd_req),
        .rf_wr_req(rf_wr_req), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'h3C00 ^ (16'(i) * 16'h0123);
    endfunction

    assign rf_rdata = mem[rf_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for writes, counters for reads and errors
    always @(negedge clk) begin
        if (!rst) begin
            if (start_err) err_cnt++;
            if (rf_rd_req) rd_cnt++;
            if (rf_wr_req) begin
                mem[rf_addr] <= rf_wdata;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R5/R6 unexpected write actual=%h expected=none", {rf_addr, rf_wdata});
                end else begin
                    logic [20:0] e;
                    e = exp_q.pop_front();
                    if ({rf_addr, rf_wdata} !== e) begin
                        fails++;
                        $display("FAIL R5 write actual=%h expected=%h", {rf_addr, rf_wdata}, e);
                    end
                end
            end
        end
    end

    task automatic mbit(input logic b, output logic smp, output logic soe);
        @(negedge clk);
        mdio_in = b;
        repeat (HALF) @(negedge clk);
        smp = mdio_out;
        soe = mdio_oe;
        mdc_in = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc_in = 1'b0;
    endtask

    task automatic frame(input int pre, input logic sbit, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rd, output logic oe_ok, output logic oe_early);
        logic s, o;
        oe_ok = 1'b1;
        oe_early = 1'b0;
        for (int i = 0; i < pre; i++) mbit(1'b1, s, o);
        mbit(1'b0, s, o);
        mbit(sbit, s, o);
        for (int i = 1; i >= 0; i--) mbit(op[i], s, o);
        for (int i = 4; i >= 0; i--) mbit(pa[i], s, o);
        for (int i = 4; i >= 0; i--) begin mbit(ra[i], s, o); oe_early |= o; end
        mbit(1'b1, s, o); oe_early |= o;
        mbit(1'b0, s, o); oe_early |= o;
        for (int i = 15; i >= 0; i--) begin
            mbit((op == 2'b10) ? 1'b1 : wd[i], s, o);
            rd[i] = s;
            oe_ok &= o;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic do_write(input int pre, input logic sbit, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                            input bit expect_wr);
        logic [15:0] r;
        logic ok, early;
        if (expect_wr) exp_q.push_back({ra, wd});
        frame(pre, sbit, op, pa, ra, wd, r, ok, early);
        chk(expect_wr ? "R5 write committed at frame end" : "R6/R2 no write",
            32'(exp_q.size()), 32'd0);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] exp,
                           input string req);
        logic [15:0] r;
        logic ok, early;
        frame(32, 1'b1, 2'b10, pa, ra, 16'h0, r, ok, early);
        chk(req, 32'(r), 32'(exp));
        chk("R4 oe high in read data phase", 32'(ok), 32'd1);
        chk("R4 oe low before data phase", 32'(early), 32'd0);
        chk("R4 oe low after frame", 32'(mdio_oe), 32'd0);
    endtask

    initial begin
        int rd0, e0;
        for (int i = 0; i < 32; i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe in reset", 32'(mdio_oe), 32'd0);
        chk("R1 wr_req in reset", 32'(rf_wr_req), 32'd0);
        chk("R1 rd_req in reset", 32'(rf_rd_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 start_err after reset", 32'(start_err), 32'd0);

        // R5 write opcodes 01, 11, 00
        do_write(32, 1'b1, 2'b01, MY_PHY, 5'd3, 16'hA55A, 1);
        do_write(32, 1'b1, 2'b11, MY_PHY, 5'd9, 16'h0F0F, 1);
        do_write(40, 1'b1, 2'b00, MY_PHY, 5'd10, 16'hFFFE, 1);

        // R3 reads back, R8 back to back frames
        rd0 = rd_cnt;
        do_read(MY_PHY, 5'd3, 16'hA55A, "R3 read after write reg3");
        do_read(MY_PHY, 5'd9, 16'h0F0F, "R8 back to back read reg9");
        do_read(MY_PHY, 5'd10, 16'hFFFE, "R3 read reg10");
        do_read(MY_PHY, 5'd7, init_val(7), "R3 read untouched reg7");
        chk("R3 one rd_req per read", 32'(rd_cnt - rd0), 32'd4);

        // R6 absent device
        rd0 = rd_cnt;
        do_read(5'h04, 5'd3, 16'hFFFF, "R6 absent device read all ones");
        chk("R6 no rd_req for absent device", 32'(rd_cnt - rd0), 32'd0);
        do_write(32, 1'b1, 2'b01, 5'h12, 5'd5, 16'h1111, 0);
        do_read(MY_PHY, 5'd5, init_val(5), "R6 absent write left reg5");

        // R2 short preamble ignored
        do_write(20, 1'b1, 2'b01, MY_PHY, 5'd6, 16'h0000, 0);
        do_read(MY_PHY, 5'd6, init_val(6), "R2 short preamble left reg6");

        // R7 bad start bit flagged, frame still runs
        e0 = err_cnt;
        do_write(32, 1'b0, 2'b01, MY_PHY, 5'd12, 16'h1234, 1);
        chk("R7 one start_err pulse", 32'(err_cnt - e0), 32'd1);
        do_read(MY_PHY, 5'd12, 16'h1234, "R7 frame executed despite bad start");
        chk("R7 no error on good frames", 32'(err_cnt - e0), 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule